// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves data between system memory and a store of numbered configuration items. Software places a 16-byte descriptor in memory and writes its address into a 64-bit trigger register. The engine then reads the descriptor through a byte-wide memory master port and decodes the control word. It may first select a new item, which sets the cursor key and clears the offset. It then does one of the following: copies item bytes out to memory, copies memory bytes into the item, or moves the offset forward. Finally it writes a status word back over the descriptor's control field.

The item store is outside the block. It answers from the engine's cursor (key and byte offset) with the item size, a read-only flag and the byte at that offset, and it accepts one byte per write strobe. The engine owns the cursor, so this cursor is the shared selection state that every access to the item store uses.

States: `S_IDLE` (wait for launch), `S_FETCH` (read 16 descriptor bytes), `S_SELECT` (apply a select), `S_DISPATCH` (choose the operation and check its bounds), `S_RD_XFER` (item byte to memory), `S_WR_FETCH` (memory byte in), `S_WR_STORE` (byte into item), `S_WRITEBACK` (4 status bytes). Transitions: `S_IDLE→S_FETCH` on launch; `S_FETCH→S_SELECT` after the 16th byte; `S_SELECT→S_DISPATCH` always. `S_DISPATCH` goes to `S_RD_XFER` for a read, to `S_WR_FETCH` for an accepted write, and to `S_WRITEBACK` for a skip, a rejected write, no operation or a zero length. `S_RD_XFER→S_WRITEBACK` and `S_WR_STORE→S_WRITEBACK` happen on the last byte. `S_WR_FETCH→S_WR_STORE` happens on memory acknowledge, and `S_WR_STORE→S_WR_FETCH` happens while bytes remain. `S_WRITEBACK→S_IDLE` happens after the 4th status byte.

Top module: `cfgdma_engine`

## Requirements
- R1: Reading the trigger register returns 0x51454D55 at the high half (`reg_half_lo`=0) and 0x20434647 at the low half (`reg_half_lo`=1), whatever was written.
- R2: A write to the low half launches an operation at address {high half, written value}. A write to the high half only stores bits 63:32. Both halves clear to zero when an operation finishes, so a later low-only launch uses zero upper bits.
- R3: The descriptor is read as 16 bytes at ascending addresses, big-endian: control word at +0, length at +4, memory address at +8.
- R4: In the control word, bit 1 is read, bit 2 is skip, bit 3 is select (new key in bits 31:16) and bit 4 is write. A select sets the key and clears the offset before any other action. After reset the key and offset are zero.
- R5: A read copies `length` item bytes from the current offset to ascending memory addresses. Bytes at or beyond the item size are copied as 0x00. The offset then advances by `length`.
- R6: A write copies `length` memory bytes into the item from the current offset, and the offset then advances by `length`.
- R7: A write is rejected as a whole if offset+length exceeds the item size or if the item is read-only. A rejected write stores no byte, keeps the offset and sets the error status.
- R8: A skip advances the offset by `length` and causes no memory access besides the descriptor fetch and the status write-back.
- R9: Read takes priority over write, and write takes priority over skip, when several operation bits are set.
- R10: The status is written as 4 bytes to the descriptor address, big-endian: 0x00000000 on success and 0x00000001 on error.
- R11: `busy` is high from launch until write-back ends. While it is high, register writes are ignored. While it is low, there is no memory or item traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Trigger register write strobe |
| reg_half_lo | input | 1 | 0 = high half (offset 0), 1 = low half (offset 4) |
| reg_wdata | input | 32 | Value written to the selected half |
| reg_rdata | output | 32 | Identification constant for the selected half |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| item_key | output | 16 | Cursor: selected item |
| item_offset | output | 32 | Cursor: byte offset in the item |
| item_size | input | 32 | Size of the selected item in bytes |
| item_ro | input | 1 | Selected item is read-only |
| item_rdata | input | 8 | Item byte at the cursor |
| item_we | output | 1 | Write one byte at the cursor |
| item_wdata | output | 8 | Byte for the item write |

## Verification
One descriptor can request select and skip together, and that pairing is the normal way to place the offset before a read or write. The offset must be cleared by the select and only then advanced by the skip, never merged. The bench uses this pairing in every sweep step and judges it through `item_key` and `item_offset` after completion. Separately, a second launch and a high-half write are issued while an operation runs. The result is judged by the cursor, the exact count of memory accesses and `busy` staying low afterwards.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SELECT,
        S_DISPATCH,
        S_RD_XFER,
        S_WR_FETCH,
        S_WR_STORE,
        S_WRITEBACK
    } dma_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned KEY_W     = 16;
    localparam int unsigned CTL_BYTES = 4;

    // positions inside the captured operation nibble (control bits 4:1)
    localparam int unsigned OP_READ   = 0;
    localparam int unsigned OP_SKIP   = 1;
    localparam int unsigned OP_SELECT = 2;
    localparam int unsigned OP_WRITE  = 3;

    localparam logic [63:0] ID_CONST = 64'h5145_4D55_2043_4647;

endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
    import cfgdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                half_lo,
    input  logic [ADDR_W/2-1:0] wdata,
    input  logic                done,
    output logic [ADDR_W/2-1:0] rdata,
    output logic [ADDR_W-1:0]   base,
    output logic                start,
    output logic                busy
);
    localparam int unsigned HALF_W = ADDR_W / 2;

    logic [HALF_W-1:0] hi_q, lo_q;
    logic              launch;

    assign launch = wr && half_lo && !busy && !done;
    assign base   = {hi_q, lo_q};
    assign rdata  = half_lo ? ID_CONST[HALF_W-1:0] : ID_CONST[ADDR_W-1:HALF_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            busy  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= launch;
            if (done) begin
                hi_q <= '0;
                lo_q <= '0;
                busy <= 1'b0;
            end else if (wr && !busy) begin
                if (half_lo) begin
                    lo_q <= wdata;
                    busy <= 1'b1;
                end else begin
                    hi_q <= wdata;
                end
            end
        end
    end

    AST_ADDR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (base == '0)); // R2
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(base)); // R11

endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor
    import cfgdma_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] load_key,
    input  logic             skip,
    input  logic [LEN_W-1:0] skip_amt,
    input  logic             step,
    output logic [KEY_W-1:0] key,
    output logic [LEN_W-1:0] offset
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key    <= '0;
            offset <= '0;
        end else if (load) begin
            key    <= load_key;
            offset <= '0;
        end else if (skip) begin
            offset <= offset + skip_amt;
        end else if (step) begin
            offset <= offset + LEN_W'(1);
        end
    end

    AST_SELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (offset == '0) && (key == $past(load_key))); // R4

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_half_lo,
    input  logic [ADDR_W/2-1:0] reg_wdata,
    output logic [ADDR_W/2-1:0] reg_rdata,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic [KEY_W-1:0]    item_key,
    output logic [LEN_W-1:0]    item_offset,
    input  logic [LEN_W-1:0]    item_size,
    input  logic                item_ro,
    input  logic [BYTE_W-1:0]   item_rdata,
    output logic                item_we,
    output logic [BYTE_W-1:0]   item_wdata
);
    localparam int unsigned LEN_BYTES  = LEN_W / BYTE_W;
    localparam int unsigned ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int unsigned DESC_BYTES = CTL_BYTES + LEN_BYTES + ADDR_BYTES;
    localparam int unsigned BCNT_W     = $clog2(DESC_BYTES);

    dma_state_e        st, nxt;
    logic [BCNT_W-1:0] bcnt;
    logic [KEY_W-1:0]  key_r;
    logic [3:0]        op_r;
    logic [LEN_W-1:0]  len_r, rem;
    logic [ADDR_W-1:0] maddr_r, ptr, base;
    logic [BYTE_W-1:0] wbuf;
    logic              err, start, done;
    logic              cur_load, cur_skip, cur_step;
    logic              fits, in_range, wr_reject;

    cfgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .half_lo (reg_half_lo),
        .wdata   (reg_wdata),
        .done    (done),
        .rdata   (reg_rdata),
        .base    (base),
        .start   (start),
        .busy    (busy)
    );

    cfgdma_cursor #(.LEN_W(LEN_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cur_load),
        .load_key (key_r),
        .skip     (cur_skip),
        .skip_amt (len_r),
        .step     (cur_step),
        .key      (item_key),
        .offset   (item_offset)
    );

    assign fits       = ({1'b0, item_offset} + {1'b0, len_r}) <= {1'b0, item_size};
    assign in_range   = item_offset < item_size;
    assign wr_reject  = item_ro || !fits;
    assign item_wdata = wbuf;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = st;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        item_we   = 1'b0;
        cur_load  = 1'b0;
        cur_skip  = 1'b0;
        cur_step  = 1'b0;
        done      = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (start) nxt = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base + ADDR_W'(bcnt);
                if (mem_ack && bcnt == BCNT_W'(DESC_BYTES - 1)) nxt = S_SELECT;
            end
            S_SELECT: begin
                cur_load = op_r[OP_SELECT];
                nxt      = S_DISPATCH;
            end
            S_DISPATCH: begin
                if (op_r[OP_READ]) begin
                    nxt = (len_r == '0) ? S_WRITEBACK : S_RD_XFER;
                end else if (op_r[OP_WRITE]) begin
                    nxt = (wr_reject || len_r == '0) ? S_WRITEBACK : S_WR_FETCH;
                end else if (op_r[OP_SKIP]) begin
                    cur_skip = 1'b1;
                    nxt      = S_WRITEBACK;
                end else begin
                    nxt = S_WRITEBACK;
                end
            end
            S_RD_XFER: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr;
                mem_wdata = in_range ? item_rdata : '0;
                if (mem_ack) begin
                    cur_step = 1'b1;
                    if (rem == LEN_W'(1)) nxt = S_WRITEBACK;
                end
            end
            S_WR_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                if (mem_ack) nxt = S_WR_STORE;
            end
            S_WR_STORE: begin
                item_we  = 1'b1;
                cur_step = 1'b1;
                nxt      = (rem == LEN_W'(1)) ? S_WRITEBACK : S_WR_FETCH;
            end
            S_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base + ADDR_W'(bcnt);
                mem_wdata = (bcnt == BCNT_W'(CTL_BYTES - 1)) ? {{(BYTE_W-1){1'b0}}, err} : '0;
                if (mem_ack && bcnt == BCNT_W'(CTL_BYTES - 1)) begin
                    done = 1'b1;
                    nxt  = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= '0;
            key_r   <= '0;
            op_r    <= '0;
            len_r   <= '0;
            maddr_r <= '0;
            ptr     <= '0;
            rem     <= '0;
            err     <= 1'b0;
            wbuf    <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    bcnt <= '0;
                    err  <= 1'b0;
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        bcnt <= bcnt + BCNT_W'(1);
                        if (bcnt == BCNT_W'(0))
                            key_r[KEY_W-1:BYTE_W] <= mem_rdata;
                        else if (bcnt == BCNT_W'(1))
                            key_r[BYTE_W-1:0] <= mem_rdata;
                        else if (bcnt == BCNT_W'(CTL_BYTES - 1))
                            op_r <= mem_rdata[4:1];
                        else if (bcnt >= BCNT_W'(CTL_BYTES) &&
                                 bcnt < BCNT_W'(CTL_BYTES + LEN_BYTES))
                            len_r <= {len_r[LEN_W-BYTE_W-1:0], mem_rdata};
                        else if (bcnt >= BCNT_W'(CTL_BYTES + LEN_BYTES))
                            maddr_r <= {maddr_r[ADDR_W-BYTE_W-1:0], mem_rdata};
                    end
                end
                S_DISPATCH: begin
                    rem <= len_r;
                    ptr <= maddr_r;
                    if (!op_r[OP_READ] && op_r[OP_WRITE] && wr_reject) err <= 1'b1;
                end
                S_RD_XFER: begin
                    if (mem_ack) begin
                        ptr <= ptr + ADDR_W'(1);
                        rem <= rem - LEN_W'(1);
                    end
                end
                S_WR_FETCH: begin
                    if (mem_ack) wbuf <= mem_rdata;
                end
                S_WR_STORE: begin
                    ptr <= ptr + ADDR_W'(1);
                    rem <= rem - LEN_W'(1);
                end
                S_WRITEBACK: begin
                    if (mem_ack) bcnt <= bcnt + BCNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !item_we)); // R11
    AST_WRITE_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        item_we |-> (item_offset < item_size) && !item_ro); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3
    AST_SKIP_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        cur_skip |=> !mem_we || (mem_addr == base)); // R8

endmodule

// File: tb/tb_cfgdma_engine.sv
module tb_cfgdma_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_half_lo;
    logic [31:0] reg_wdata, reg_rdata;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] item_key;
    logic [31:0] item_offset, item_size;
    logic        item_ro, item_we;
    logic [7:0]  item_rdata, item_wdata;

    logic [7:0]  mem   [256];
    logic [7:0]  store [4][32];
    logic [7:0]  shadow[4][32];
    logic        tb_wr_en, tb_clr, seen;
    logic [7:0]  tb_wr_addr, tb_wr_data;
    logic [31:0] first_hi;
    int          acc_cnt;
    int          n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_half_lo(reg_half_lo),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .item_key(item_key), .item_offset(item_offset), .item_size(item_size),
        .item_ro(item_ro), .item_rdata(item_rdata), .item_we(item_we),
        .item_wdata(item_wdata)
    );

    function automatic int sz(input int k);
        case (k)
            0: return 8;
            1: return 16;
            2: return 5;
            default: return 32;
        endcase
    endfunction

    assign item_size  = 32'(sz(int'(item_key[1:0])));
    assign item_ro    = (item_key[1:0] == 2'd1);
    assign item_rdata = (item_offset < 32) ? store[item_key[1:0]][item_offset[4:0]] : 8'h00;

    // memory model: each access acknowledged one cycle after request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_rdata <= 8'h00; acc_cnt <= 0; seen <= 1'b0; first_hi <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else begin
            if (tb_clr) begin acc_cnt <= 0; seen <= 1'b0; end
            if (tb_wr_en) mem[tb_wr_addr] <= tb_wr_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    if (!seen) begin seen <= 1'b1; first_hi <= mem_addr[63:32]; end
                end
            end else mem_ack <= 1'b0;
        end
    end

    // item store model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++)
                for (int i = 0; i < 32; i++) store[k][i] <= 8'(k*16 + i + 1);
        end else if (item_we) begin
            store[item_key[1:0]][item_offset[4:0]] <= item_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] d);
        tb_wr_en = 1'b1; tb_wr_addr = a; tb_wr_data = d;
        @(negedge clk);
        tb_wr_en = 1'b0;
    endtask

    task automatic reg_write(input logic lo, input logic [31:0] d);
        reg_wr = 1'b1; reg_half_lo = lo; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic launch(input logic [7:0] base, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [7:0] dst, input bit use_hi, input logic [31:0] hi);
        for (int i = 0; i < 4; i++) put(base + 8'(i), ctl[31-8*i -: 8]);
        for (int i = 0; i < 4; i++) put(base + 8'(4 + i), len[31-8*i -: 8]);
        for (int i = 0; i < 7; i++) put(base + 8'(8 + i), 8'h00);
        put(base + 8'd15, dst);
        tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
        if (use_hi) reg_write(1'b0, hi);
        reg_write(1'b1, {24'h0, base});
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, "R11 busy timeout", 64'(n), 64'd0);
    endtask

    task automatic run_op(input logic [7:0] base, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [7:0] dst);
        launch(base, ctl, len, dst, 1'b0, 32'h0);
        wait_done();
    endtask

    function automatic logic [31:0] status_at(input logic [7:0] b);
        return {mem[b], mem[b+8'd1], mem[b+8'd2], mem[b+8'd3]};
    endfunction

    function automatic int store_diff(input int k);
        int d = 0;
        for (int i = 0; i < 32; i++) if (store[k][i] !== shadow[k][i]) d++;
        return d;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_half_lo = 1'b0; reg_wdata = '0;
        tb_wr_en = 1'b0; tb_clr = 1'b0; tb_wr_addr = '0; tb_wr_data = '0;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 32; i++) shadow[k][i] = 8'(k*16 + i + 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
        chk(mem_req == 1'b0, "R11 no request after reset", 64'(mem_req), 64'd0);
        chk(item_key == 16'd0 && item_offset == 32'd0, "R4 cursor reset",
            {item_key, item_offset}, 64'd0);

        // R1: identification constant
        reg_half_lo = 1'b0; #1;
        chk(reg_rdata == 32'h51454D55, "R1 high half", 64'(reg_rdata), 64'h51454D55);
        reg_half_lo = 1'b1; #1;
        chk(reg_rdata == 32'h20434647, "R1 low half", 64'(reg_rdata), 64'h20434647);
        @(negedge clk);

        // R3 R4 R5 R8 R10: select+skip then read sweep
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 3; s++)
                for (int L = 0; L < 7; L++) begin
                    put(8'h00, 8'hFF);
                    run_op(8'h00, (32'(k) << 16) | 32'h0C, 32'(s), 8'h80);
                    chk(item_key == 16'(k) && item_offset == 32'(s), "R4 R8 select+skip cursor",
                        {item_key, item_offset}, {16'(k), 32'(s)});
                    chk(acc_cnt == 20, "R8 skip traffic", 64'(acc_cnt), 64'd20);
                    chk(status_at(8'h00) == 32'h0, "R10 skip status", 64'(status_at(8'h00)), 64'd0);
                    for (int i = 0; i < 8; i++) put(8'h80 + 8'(i), 8'hEE);
                    run_op(8'h00, 32'h2, 32'(L), 8'h80);
                    for (int i = 0; i < L; i++) begin
                        logic [7:0] e;
                        e = (s + i < sz(k)) ? 8'(k*16 + s + i + 1) : 8'h00;
                        chk(mem[8'h80 + 8'(i)] == e, "R5 R3 read byte", 64'(mem[8'h80 + 8'(i)]), 64'(e));
                    end
                    chk(mem[8'h80 + 8'(L)] == 8'hEE, "R5 no overrun", 64'(mem[8'h80 + 8'(L)]), 64'hEE);
                    chk(item_offset == 32'(s + L), "R5 offset advance", 64'(item_offset), 64'(s + L));
                    chk(acc_cnt == 20 + L, "R5 read traffic", 64'(acc_cnt), 64'(20 + L));
                end

        // R6 R7 R10: write sweep
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 7; s++)
                for (int L = 0; L < 5; L++) begin
                    bit ee;
                    ee = (k == 1) || (s + L > sz(k));
                    run_op(8'h00, (32'(k) << 16) | 32'h0C, 32'(s), 8'h80);
                    for (int i = 0; i < L; i++) put(8'h90 + 8'(i), 8'(s*7 + L*3 + i + 8'h40));
                    run_op(8'h00, 32'h10, 32'(L), 8'h90);
                    if (!ee) for (int i = 0; i < L; i++) shadow[k][s + i] = 8'(s*7 + L*3 + i + 8'h40);
                    chk(status_at(8'h00) == 32'(ee), "R10 R7 write status",
                        64'(status_at(8'h00)), 64'(ee));
                    chk(store_diff(k) == 0, "R6 R7 item contents", 64'(store_diff(k)), 64'd0);
                    chk(item_offset == 32'(ee ? s : s + L), "R6 R7 offset after write",
                        64'(item_offset), 64'(ee ? s : s + L));
                    chk(acc_cnt == 20 + (ee ? 0 : L), "R7 write traffic",
                        64'(acc_cnt), 64'(20 + (ee ? 0 : L)));
                end

        // R9: read beats write and skip
        run_op(8'h00, 32'h0003_001E, 32'd2, 8'h80);
        chk(mem[8'h80] == 8'h31 && mem[8'h81] == 8'h32, "R9 read wins",
            {mem[8'h80], mem[8'h81]}, 16'h3132);
        chk(store_diff(3) == 0, "R9 item untouched", 64'(store_diff(3)), 64'd0);
        chk(item_offset == 32'd2, "R9 offset after read", 64'(item_offset), 64'd2);
        // R9: write beats skip
        put(8'h90, 8'hAA); put(8'h91, 8'hBB);
        run_op(8'h00, 32'h14, 32'd2, 8'h90);
        shadow[3][2] = 8'hAA; shadow[3][3] = 8'hBB;
        chk(store_diff(3) == 0, "R9 write wins over skip", 64'(store_diff(3)), 64'd0);
        chk(item_offset == 32'd4, "R9 offset after write", 64'(item_offset), 64'd4);

        // R2: 64-bit address, then cleared upper half
        launch(8'h20, 32'h0, 32'd0, 8'h80, 1'b1, 32'h0000_1234);
        wait_done();
        chk(first_hi == 32'h1234, "R2 upper address bits", 64'(first_hi), 64'h1234);
        run_op(8'h20, 32'h0, 32'd0, 8'h80);
        chk(first_hi == 32'h0, "R2 upper half cleared", 64'(first_hi), 64'h0);
        chk(status_at(8'h20) == 32'h0, "R10 empty op status", 64'(status_at(8'h20)), 64'd0);

        // R11: triggers while busy are ignored
        for (int i = 0; i < 4; i++) put(8'h40 + 8'(i), (i == 3) ? 8'h0C : 8'h00);
        for (int i = 0; i < 4; i++) put(8'h44 + 8'(i), (i == 3) ? 8'h05 : 8'h00);
        launch(8'h00, 32'h0003_000A, 32'd8, 8'hA0, 1'b0, 32'h0);
        chk(busy == 1'b1, "R11 busy after launch", 64'(busy), 64'd1);
        reg_write(1'b1, 32'h40);
        reg_write(1'b0, 32'h77);
        wait_done();
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R11 no second launch", 64'(busy), 64'd0);
        chk(item_key == 16'd3 && item_offset == 32'd8, "R11 cursor from first op only",
            {item_key, item_offset}, {16'd3, 32'd8});
        chk(acc_cnt == 28, "R11 traffic of one op", 64'(acc_cnt), 64'd28);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule